// File: doc/BRIEF.md
# Indirect Register Access Sequencer

This block gives a host access to registers that cannot be addressed directly. Such registers sit behind a pair of directly addressable registers: a command register and a data register. For each host operation, the sequencer runs a fixed series of transfers on a master port. It issues those transfers to a separate direct-access engine, which is not part of this block.

A host operation carries:
- a direction;
- a 16-bit target address;
- a byte count of one to four;
- write data, for writes.

From these, the sequencer composes a 32-bit command word and writes it to the command register. It then reads the command register back until the busy flag clears. For a write, the data register is loaded before the command is issued. For a read, the data register is fetched only once busy has cleared.

Busy polling is bounded by a parameter. If that bound runs out, the operation ends with an error flag instead of hanging the host.

Top module: `ind_reg_seq`

## Requirements
- R1: After reset `h_ready` is 1, while `h_done`, `h_err`, `m_req` and `h_rdata` are all 0.
- R2: The command word written to the command register has this layout:
  - bits 7:0: target address low byte.
  - bits 15:8: target address high byte.
  - bits 23:16: byte count, from 1 to 4, equal to `h_len`+1.
  - bits 31:24: opcode, 0xC0 for a read and 0x80 for a write.
- R3: A write first writes `h_wdata` to the data register with a 4-byte length (`m_len`=3), and only then writes the command word.
- R4: A read first writes the command word, then polls. Once busy has cleared, it reads the data register with `m_len` equal to `h_len`.
- R5: Each poll is a 4-byte read (`m_len`=3) of the command register. Polling repeats for as long as bit 31 of the returned word is 1, and no other returned bit affects the decision.
- R6: After `MAX_POLLS` polls that all return busy, the sequencer:
  - issues no further master request;
  - skips the data read;
  - ends the operation with `h_err` high together with the `h_done` pulse.
- R7: `h_done` is a single-cycle pulse in the cycle after the final master acknowledge. `h_err` is low when the operation succeeds.
- R8: On a successful read, `h_rdata` takes the returned bytes below the requested count, with the upper bytes 0. It then holds that value through writes and failed reads until the next successful read.
- R9: A host request raised while `h_ready` is 0 has no effect: it causes no extra master transfers and does not change the operation in flight.
- R10: While `m_req` is high and `m_ack` is low, `m_req` stays high and `m_wr`, `m_addr`, `m_len` and `m_wdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_req | input | 1 | Host request, taken when `h_ready` is 1 |
| h_wr | input | 1 | 1 = write, 0 = read |
| h_addr | input | 16 | Target indirect register address |
| h_len | input | 2 | Byte count minus one |
| h_wdata | input | 32 | Write data |
| h_ready | output | 1 | Sequencer idle and able to accept a request |
| h_done | output | 1 | One-cycle completion pulse |
| h_err | output | 1 | Poll timeout, valid with `h_done` |
| h_rdata | output | 32 | Last successful read data |
| m_req | output | 1 | Master transfer request, held until acknowledged |
| m_wr | output | 1 | Master transfer direction, 1 = write |
| m_addr | output | 16 | Direct register address |
| m_len | output | 2 | Master transfer byte count minus one |
| m_wdata | output | 32 | Master write data |
| m_ack | input | 1 | One-cycle acknowledge from the direct engine |
| m_rdata | input | 32 | Read data, valid with `m_ack` |

## Verification
A wrong sequencing state shows up on the master port at the very next acknowledge: a transfer with the wrong address, direction or length, or an extra transfer. The reference model compares each of these against its expected list of transfers as it happens. An off-by-one in the poll counter appears as one transfer too many or too few, right at the poll limit. A fault in the completion path shows one cycle after the final acknowledge, as a missing or doubled done pulse, a wrong error flag, or a read value that is not masked or not held.

// File: rtl/ind_pkg.sv
package ind_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int LEN_W  = 2;
    localparam int NBYTES = DATA_W / 8;

    localparam logic [7:0] OP_READ  = 8'hC0;
    localparam logic [7:0] OP_WRITE = 8'h80;
    localparam int         BUSY_BIT = DATA_W - 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DATA_WR,
        ST_CMD_WR,
        ST_POLL,
        ST_DATA_RD,
        ST_FIN
    } seq_state_e;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic [DATA_W-1:0] wdata;
    } host_req_t;

    typedef struct packed {
        logic              req;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic [DATA_W-1:0] wdata;
    } mst_cmd_t;

    function automatic logic [DATA_W-1:0] build_cmd(input host_req_t r);
        logic [7:0] count;
        count = 8'(r.len) + 8'd1;
        return {(r.wr ? OP_WRITE : OP_READ), count, r.addr};
    endfunction

    function automatic logic [DATA_W-1:0] mask_bytes(input logic [DATA_W-1:0] d,
                                                     input logic [LEN_W-1:0]  len);
        logic [DATA_W-1:0] o;
        o = '0;
        for (int b = 0; b < NBYTES; b++) begin
            if (b <= int'(len)) o[b*8 +: 8] = d[b*8 +: 8];
        end
        return o;
    endfunction

endpackage

// File: rtl/ind_req_latch.sv
module ind_req_latch
    import ind_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              h_wr,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [LEN_W-1:0]  h_len,
    input  logic [DATA_W-1:0] h_wdata,
    input  logic              capture,
    input  logic [DATA_W-1:0] m_rdata,
    output host_req_t         lat,
    output logic [DATA_W-1:0] rdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            lat   <= '0;
            rdata <= '0;
        end else begin
            if (accept) begin
                lat.wr    <= h_wr;
                lat.addr  <= h_addr;
                lat.len   <= h_len;
                lat.wdata <= h_wdata;
            end
            if (capture) rdata <= mask_bytes(m_rdata, lat.len);
        end
    end

endmodule

// File: rtl/ind_poll_timer.sv
module ind_poll_timer #(
    parameter int MAX_POLLS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic last
);

    localparam int CNT_W = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
    localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(MAX_POLLS - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (inc && cnt != LAST_VAL) cnt <= cnt + 1'b1;
    end

    assign last = (cnt == LAST_VAL);

endmodule

// File: rtl/ind_seq_ctrl.sv
module ind_seq_ctrl
    import ind_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       h_req,
    input  logic       h_wr,
    input  logic       lat_wr,
    input  logic       m_ack,
    input  logic       m_busy,
    input  logic       poll_last,
    output seq_state_e state,
    output logic       accept,
    output logic       poll_clr,
    output logic       poll_inc,
    output logic       capture,
    output logic       err_q
);

    seq_state_e nxt;
    logic       err_set;

    assign accept   = (state == ST_IDLE) && h_req;
    assign poll_clr = (state == ST_CMD_WR) && m_ack;
    assign poll_inc = (state == ST_POLL) && m_ack;
    assign capture  = (state == ST_DATA_RD) && m_ack;

    always_comb begin
        nxt     = state;
        err_set = 1'b0;
        case (state)
            ST_IDLE:    if (h_req) nxt = h_wr ? ST_DATA_WR : ST_CMD_WR;
            ST_DATA_WR: if (m_ack) nxt = ST_CMD_WR;
            ST_CMD_WR:  if (m_ack) nxt = ST_POLL;
            ST_POLL: begin
                if (m_ack) begin
                    if (!m_busy) begin
                        nxt = lat_wr ? ST_FIN : ST_DATA_RD;
                    end else if (poll_last) begin
                        nxt     = ST_FIN;
                        err_set = 1'b1;
                    end
                end
            end
            ST_DATA_RD: if (m_ack) nxt = ST_FIN;
            ST_FIN:     nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            err_q <= 1'b0;
        end else begin
            state <= nxt;
            if (accept)       err_q <= 1'b0;
            else if (err_set) err_q <= 1'b1;
        end
    end

endmodule

// File: rtl/ind_mst_drive.sv
module ind_mst_drive
    import ind_pkg::*;
#(
    parameter logic [ADDR_W-1:0] CMD_REG_ADDR  = 16'h0304,
    parameter logic [ADDR_W-1:0] DATA_REG_ADDR = 16'h0300
) (
    input  seq_state_e state,
    input  host_req_t  lat,
    output mst_cmd_t   cmd
);

    localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(NBYTES - 1);

    always_comb begin
        cmd      = '0;
        cmd.len  = FULL_LEN;
        case (state)
            ST_DATA_WR: begin
                cmd.req   = 1'b1;
                cmd.wr    = 1'b1;
                cmd.addr  = DATA_REG_ADDR;
                cmd.wdata = lat.wdata;
            end
            ST_CMD_WR: begin
                cmd.req   = 1'b1;
                cmd.wr    = 1'b1;
                cmd.addr  = CMD_REG_ADDR;
                cmd.wdata = build_cmd(lat);
            end
            ST_POLL: begin
                cmd.req  = 1'b1;
                cmd.addr = CMD_REG_ADDR;
            end
            ST_DATA_RD: begin
                cmd.req  = 1'b1;
                cmd.addr = DATA_REG_ADDR;
                cmd.len  = lat.len;
            end
            default: cmd = '0;
        endcase
    end

endmodule

// File: rtl/ind_reg_seq.sv
module ind_reg_seq
    import ind_pkg::*;
#(
    parameter logic [ADDR_W-1:0] CMD_REG_ADDR  = 16'h0304,
    parameter logic [ADDR_W-1:0] DATA_REG_ADDR = 16'h0300,
    parameter int                MAX_POLLS     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              h_req,
    input  logic              h_wr,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [LEN_W-1:0]  h_len,
    input  logic [DATA_W-1:0] h_wdata,
    output logic              h_ready,
    output logic              h_done,
    output logic              h_err,
    output logic [DATA_W-1:0] h_rdata,
    output logic              m_req,
    output logic              m_wr,
    output logic [ADDR_W-1:0] m_addr,
    output logic [LEN_W-1:0]  m_len,
    output logic [DATA_W-1:0] m_wdata,
    input  logic              m_ack,
    input  logic [DATA_W-1:0] m_rdata
);

    seq_state_e state;
    host_req_t  lat;
    mst_cmd_t   cmd;
    logic       accept, poll_clr, poll_inc, poll_last, capture, err_q;

    ind_seq_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .h_req     (h_req),
        .h_wr      (h_wr),
        .lat_wr    (lat.wr),
        .m_ack     (m_ack),
        .m_busy    (m_rdata[BUSY_BIT]),
        .poll_last (poll_last),
        .state     (state),
        .accept    (accept),
        .poll_clr  (poll_clr),
        .poll_inc  (poll_inc),
        .capture   (capture),
        .err_q     (err_q)
    );

    ind_req_latch u_latch (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .h_wr    (h_wr),
        .h_addr  (h_addr),
        .h_len   (h_len),
        .h_wdata (h_wdata),
        .capture (capture),
        .m_rdata (m_rdata),
        .lat     (lat),
        .rdata   (h_rdata)
    );

    ind_poll_timer #(.MAX_POLLS(MAX_POLLS)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .clr  (poll_clr),
        .inc  (poll_inc),
        .last (poll_last)
    );

    ind_mst_drive #(
        .CMD_REG_ADDR  (CMD_REG_ADDR),
        .DATA_REG_ADDR (DATA_REG_ADDR)
    ) u_drive (
        .state (state),
        .lat   (lat),
        .cmd   (cmd)
    );

    assign h_ready = (state == ST_IDLE);
    assign h_done  = (state == ST_FIN);
    assign h_err   = (state == ST_FIN) && err_q;
    assign m_req   = cmd.req;
    assign m_wr    = cmd.wr;
    assign m_addr  = cmd.addr;
    assign m_len   = cmd.len;
    assign m_wdata = cmd.wdata;

endmodule

// File: rtl/ind_reg_seq_chk.sv
module ind_reg_seq_chk
    import ind_pkg::*;
#(
    parameter logic [ADDR_W-1:0] CMD_ADDR = 16'h0304
) (
    input logic              clk,
    input logic              rst,
    input logic              h_ready,
    input logic              h_done,
    input logic              h_err,
    input logic [DATA_W-1:0] h_rdata,
    input logic              m_req,
    input logic              m_wr,
    input logic [ADDR_W-1:0] m_addr,
    input logic [LEN_W-1:0]  m_len,
    input logic [DATA_W-1:0] m_wdata,
    input logic              m_ack
);

    p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (m_req && !m_ack) |=> (m_req && $stable(m_wr) && $stable(m_addr)
                               && $stable(m_len) && $stable(m_wdata)));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        h_done |=> !h_done);

    p_done_after_ack_r7: assert property (@(posedge clk) disable iff (rst)
        h_done |-> $past(m_ack));

    p_err_with_done_r6: assert property (@(posedge clk) disable iff (rst)
        h_err |-> h_done);

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        h_ready |-> !m_req);

    p_rdata_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !$stable(h_rdata) |-> h_done);

    p_opcode_r2: assert property (@(posedge clk) disable iff (rst)
        (m_req && m_wr && m_addr == CMD_ADDR) |->
            (m_wdata[31:24] == 8'h80 || m_wdata[31:24] == 8'hC0));

    p_poll_len_r5: assert property (@(posedge clk) disable iff (rst)
        (m_req && !m_wr && m_addr == CMD_ADDR) |-> (m_len == 2'd3));

endmodule

bind ind_reg_seq ind_reg_seq_chk #(.CMD_ADDR(CMD_REG_ADDR)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .h_ready (h_ready),
    .h_done  (h_done),
    .h_err   (h_err),
    .h_rdata (h_rdata),
    .m_req   (m_req),
    .m_wr    (m_wr),
    .m_addr  (m_addr),
    .m_len   (m_len),
    .m_wdata (m_wdata),
    .m_ack   (m_ack)
);

// File: tb/ind_reg_seq_tb.sv
module ind_reg_seq_tb;

    localparam int          MAXP  = 8;
    localparam logic [15:0] CMDA  = 16'h0304;
    localparam logic [15:0] DATAA = 16'h0300;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        h_req = 1'b0, h_wr = 1'b0;
    logic [15:0] h_addr = '0;
    logic [1:0]  h_len = '0;
    logic [31:0] h_wdata = '0;
    logic        h_ready, h_done, h_err;
    logic [31:0] h_rdata;
    logic        m_req, m_wr;
    logic [15:0] m_addr;
    logic [1:0]  m_len;
    logic [31:0] m_wdata;
    logic        m_ack = 1'b0;
    logic [31:0] m_rdata = '0;

    typedef struct packed {
        logic        wr;
        logic [15:0] addr;
        logic [1:0]  len;
        logic [31:0] wdata;
        logic [31:0] resp;
        logic        fin;
        logic        err;
        logic        upd;
        logic [31:0] newr;
    } xact_t;

    xact_t       exq[$];
    int          lat = 1;
    int          n_chk = 0, n_fail = 0;
    bit          finished = 0;
    bit          exp_done = 0, exp_err = 0;
    logic [31:0] exp_rdata = '0;

    always #4 clk = ~clk;

    ind_reg_seq #(
        .CMD_REG_ADDR  (CMDA),
        .DATA_REG_ADDR (DATAA),
        .MAX_POLLS     (MAXP)
    ) u_dut (
        .clk(clk), .rst(rst),
        .h_req(h_req), .h_wr(h_wr), .h_addr(h_addr), .h_len(h_len), .h_wdata(h_wdata),
        .h_ready(h_ready), .h_done(h_done), .h_err(h_err), .h_rdata(h_rdata),
        .m_req(m_req), .m_wr(m_wr), .m_addr(m_addr), .m_len(m_len), .m_wdata(m_wdata),
        .m_ack(m_ack), .m_rdata(m_rdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] keep_low(input logic [31:0] d, input logic [1:0] len);
        logic [31:0] o = '0;
        for (int b = 0; b <= int'(len); b++) o[b*8 +: 8] = d[b*8 +: 8];
        return o;
    endfunction

    function automatic xact_t mk(input logic wr, input logic [15:0] a, input logic [1:0] l,
                                 input logic [31:0] wd, input logic [31:0] rsp,
                                 input logic fin, input logic err, input logic upd,
                                 input logic [31:0] nr);
        xact_t x;
        x.wr = wr; x.addr = a; x.len = l; x.wdata = wd; x.resp = rsp;
        x.fin = fin; x.err = err; x.upd = upd; x.newr = nr;
        return x;
    endfunction

    // Engine model and per-clock comparison
    initial begin
        int wc = 0;
        xact_t e;
        @(negedge clk);
        while (rst) @(negedge clk);
        forever begin
            @(negedge clk);
            chk(h_done == exp_done, "R7 done timing", 32'(h_done), 32'(exp_done));
            if (exp_done) chk(h_err == exp_err, "R6 error flag", 32'(h_err), 32'(exp_err));
            chk(h_rdata == exp_rdata, "R8 read data", h_rdata, exp_rdata);
            exp_done = 0;
            m_ack = 1'b0;
            if (m_req) begin
                if (wc >= lat) begin
                    wc = 0;
                    if (exq.size() == 0) begin
                        chk(0, "R6/R9 unexpected master request", {16'h0, m_addr}, 32'h0);
                        m_ack   = 1'b1;
                        m_rdata = 32'h0;
                    end else begin
                        e = exq.pop_front();
                        chk(m_wr == e.wr, "R3/R4 transfer direction", 32'(m_wr), 32'(e.wr));
                        chk(m_addr == e.addr, "R3/R4 transfer address", 32'(m_addr), 32'(e.addr));
                        chk(m_len == e.len, "R4/R5 transfer length", 32'(m_len), 32'(e.len));
                        if (e.wr) chk(m_wdata == e.wdata, "R2/R3 write data", m_wdata, e.wdata);
                        m_ack   = 1'b1;
                        m_rdata = e.resp;
                        if (e.fin) begin
                            exp_done = 1;
                            exp_err  = e.err;
                            if (e.upd) exp_rdata = e.newr;
                        end
                    end
                end else begin
                    wc++;
                end
            end else begin
                wc = 0;
            end
        end
    end

    task automatic run_op(input logic wr, input logic [15:0] a, input logic [1:0] l,
                          input logic [31:0] wd, input int nbusy, input logic [31:0] rd,
                          input bit intrude);
        logic [31:0] cmdw;
        int          np;
        cmdw = {(wr ? 8'h80 : 8'hC0), 8'(l) + 8'd1, a};
        np   = (nbusy < MAXP) ? nbusy : MAXP;
        if (wr) exq.push_back(mk(1, DATAA, 2'd3, wd, 32'h0, 0, 0, 0, 0));
        exq.push_back(mk(1, CMDA, 2'd3, cmdw, 32'h0, 0, 0, 0, 0));
        for (int i = 0; i < np; i++)
            exq.push_back(mk(0, CMDA, 2'd3, 0, 32'h8123_4567,
                             (nbusy >= MAXP) && (i == np - 1),
                             (nbusy >= MAXP) && (i == np - 1), 0, 0));
        if (nbusy < MAXP) begin
            exq.push_back(mk(0, CMDA, 2'd3, 0, 32'h7FFF_FFFF, wr, 0, 0, 0));
            if (!wr) exq.push_back(mk(0, DATAA, l, 0, rd, 1, 0, 1, keep_low(rd, l)));
        end
        while (!h_ready) @(negedge clk);
        h_req = 1'b1; h_wr = wr; h_addr = a; h_len = l; h_wdata = wd;
        @(negedge clk);
        h_req = 1'b0;
        if (intrude) begin
            @(negedge clk);
            chk(h_ready == 1'b0, "R9 busy while in flight", 32'(h_ready), 32'h0);
            h_req = 1'b1; h_wr = ~wr; h_addr = 16'hDEAD; h_len = 2'd1; h_wdata = 32'hFFFF_0000;
            @(negedge clk);
            h_req = 1'b0;
        end
        while (exq.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk(h_ready == 1'b1, "R1 ready after reset", 32'(h_ready), 32'h1);
        chk(h_done == 1'b0, "R1 done after reset", 32'(h_done), 32'h0);
        chk(h_err == 1'b0, "R1 err after reset", 32'(h_err), 32'h0);
        chk(m_req == 1'b0, "R1 master idle after reset", 32'(m_req), 32'h0);
        chk(h_rdata == 32'h0, "R1 rdata after reset", h_rdata, 32'h0);
        // R3 R2 R5 R7: write, no busy
        lat = 2; run_op(1, 16'h0123, 2'd3, 32'hA5A5_1234, 0, 0, 0);
        // R4 R8: one-byte read after two busy polls
        lat = 1; run_op(0, 16'h0A0B, 2'd0, 0, 2, 32'hDEAD_BEEF, 0);
        // R5 R6 boundary: busy on MAXP-1 polls still succeeds
        lat = 0; run_op(0, 16'hF00F, 2'd1, 0, MAXP - 1, 32'h1122_3344, 0);
        // R6: read timeout, rdata held (R8)
        lat = 3; run_op(0, 16'h4455, 2'd2, 0, MAXP, 32'h9999_9999, 0);
        // R6: write timeout
        lat = 0; run_op(1, 16'h8001, 2'd1, 32'h0BAD_F00D, MAXP + 3, 0, 0);
        // R8: full four-byte read
        lat = 2; run_op(0, 16'h7F80, 2'd3, 0, 1, 32'hCAFE_F00D, 0);
        // R9: host requests during a write and a read
        lat = 3; run_op(1, 16'h0200, 2'd2, 32'h1357_9BDF, 3, 0, 1);
        lat = 2; run_op(0, 16'h3C3C, 2'd2, 0, 0, 32'h89AB_CDEF, 1);
        // R2: three-byte count field with zero address
        lat = 1; run_op(1, 16'h0000, 2'd2, 32'h0, 0, 0, 0);
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule